// File: doc/BRIEF.md
# Two-Way LRU Word Cache

This block is a small read cache placed between a pipeline's data port and a slow main memory. It stores eight 32-bit words arranged as four sets of two ways. Each line is a single word, so a word address splits into a set index and a tag with no offset field. A load that hits returns its word in the same cycle. A load that misses raises `stall`, issues one read to memory, and waits for the word. It then writes the word into a free way, or into the least recently used way if both are valid, and returns the word to the requester.

Stores always pass straight through to memory. They never stall and never allocate a line. If the stored address is already cached, the cached copy is updated too. Only loads update the recency state of a set. A running count of stall cycles is kept so that miss cost can be profiled.

The requester holds its request stable for as long as `stall` is high. Addresses are word addresses: bits [1:0] select the set and the upper bits form the tag.

Top module: `wordcache_2w`

## Requirements
- R1: A load whose tag matches a valid way of its set returns that way's word on `rsp_rdata` in the same cycle, with `stall` low and no memory read.
- R2: A load miss drives `stall` high from the cycle the miss is seen until the fetched word is returned. It pulses `mem_rd_req` for exactly that first cycle, with `mem_addr` equal to the request address. With a memory that answers `mem_rd_valid` 5 cycles after the request, the load stalls for exactly 5 cycles.
- R3: In the cycle `mem_rd_valid` is high, the fetched word appears on `rsp_rdata` with `stall` low. The word fills an invalid way of the set if one exists, otherwise the least recently used way. The other way keeps its contents.
- R4: A load hit or a fill makes the used way most recent. Stores never change the recency state.
- R5: A store never stalls. In its cycle it drives `mem_wr_req` high with `mem_addr`/`mem_wdata` equal to the request, and it raises no read.
- R6: A store whose address is not cached allocates no line, so a later load of that address misses and returns the stored value from memory.
- R7: A store whose address is cached also updates the cached word, so a later load hits and returns the new value.
- R8: `miss_cycles` increases by one in every cycle in which `stall` is high and holds otherwise.
- R9: After reset every way is invalid, `stall` is low and `miss_cycles` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Store data |
| rsp_rdata | output | DATA_W | Load data, valid when a load is present and stall is low |
| stall | output | 1 | Requester must hold its request |
| mem_rd_req | output | 1 | One-cycle memory read request |
| mem_wr_req | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rd_valid | input | 1 | Memory read data valid |
| mem_rd_data | input | DATA_W | Memory read data |
| miss_cycles | output | CNT_W | Total stall cycles since reset |

## Verification
A wrong recency bit or a wrong victim choice shows no fault on its own. It appears only when a third tag is loaded into the same set, and then as a later reload stalling when it should hit, or hitting when it should stall. For this reason every set is driven through a fixed sequence that ends with reloads of both evicted and kept tags. A stale data word shows up at once as a wrong `rsp_rdata` on the next hit. A count or stall-length error shows up as a stall run that is not exactly 5 cycles, and as `miss_cycles` drifting from five times the number of misses, which is checked after each set.

// File: rtl/wc_pkg.sv
package wc_pkg;

    localparam int DEF_ADDR_W = 10;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_SETS   = 4;
    localparam int DEF_CNT_W  = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } wc_state_e;

    typedef struct packed {
        logic hit;
        logic way;
        logic victim;
    } wc_lookup_t;

    // free way first (way 0 preferred), else the least recently used way
    function automatic logic pick_victim(input logic [1:0] vld, input logic lru_way);
        if (!vld[0])      return 1'b0;
        else if (!vld[1]) return 1'b1;
        else              return lru_way;
    endfunction

endpackage

// File: rtl/wc_store.sv
module wc_store
    import wc_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int SETS   = DEF_SETS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_addr,
    output wc_lookup_t        lk_res,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic              wr_fill,
    input  logic              wr_way,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lru_touch,
    input  logic              lru_used
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [TAG_W-1:0]  tag_q   [SETS][2];
    logic [DATA_W-1:0] data_q  [SETS][2];
    logic [1:0]        valid_q [SETS];
    logic              lru_q   [SETS];   // index of the least recently used way

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic [1:0]       way_hit;

    assign idx = lk_addr[IDX_W-1:0];
    assign tag = lk_addr[ADDR_W-1:IDX_W];

    for (genvar w = 0; w < 2; w++) begin : g_way
        assign way_hit[w] = valid_q[idx][w] && (tag_q[idx][w] == tag);
    end

    always_comb begin
        lk_res.hit    = |way_hit;
        lk_res.way    = way_hit[1];
        lk_res.victim = pick_victim(valid_q[idx], lru_q[idx]);
        lk_data       = data_q[idx][way_hit[1]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                lru_q[s]   <= 1'b0;
                for (int w = 0; w < 2; w++) begin
                    tag_q[s][w]  <= '0;
                    data_q[s][w] <= '0;
                end
            end
        end else begin
            if (wr_en) begin
                data_q[idx][wr_way] <= wr_data;
                if (wr_fill) begin
                    tag_q[idx][wr_way]   <= tag;
                    valid_q[idx][wr_way] <= 1'b1;
                end
            end
            if (lru_touch) begin
                lru_q[idx] <= ~lru_used;
            end
        end
    end
endmodule

// File: rtl/wc_ctrl.sv
module wc_ctrl
    import wc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_write,
    input  logic lk_hit,
    input  logic mem_rd_valid,
    output logic stall,
    output logic mem_rd_req,
    output logic mem_wr_req,
    output logic load_hit,
    output logic fill_now,
    output logic store_hit
);
    wc_state_e state_q, state_d;
    logic idle, load_req, miss;

    assign idle     = (state_q == ST_IDLE);
    assign load_req = idle && req_valid && !req_write;
    assign miss     = load_req && !lk_hit;

    assign load_hit   = load_req && lk_hit;
    assign fill_now   = !idle && mem_rd_valid;
    assign store_hit  = idle && req_valid && req_write && lk_hit;
    assign mem_rd_req = miss;
    assign mem_wr_req = idle && req_valid && req_write;
    assign stall      = miss || (!idle && !mem_rd_valid);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (miss)         state_d = ST_FILL;
            ST_FILL: if (mem_rd_valid) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/wc_stallcnt.sv
module wc_stallcnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)        count <= '0;
        else if (stall) count <= count + 1'b1;
    end
endmodule

// File: rtl/wordcache_2w.sv
module wordcache_2w
    import wc_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int SETS   = DEF_SETS,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              stall,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic [CNT_W-1:0]  miss_cycles
);
    wc_lookup_t        lk_res;
    logic [DATA_W-1:0] lk_data;
    logic              load_hit, fill_now, store_hit;
    logic              wr_en, wr_way, lru_touch;
    logic [DATA_W-1:0] wr_data;

    wc_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .lk_hit       (lk_res.hit),
        .mem_rd_valid (mem_rd_valid),
        .stall        (stall),
        .mem_rd_req   (mem_rd_req),
        .mem_wr_req   (mem_wr_req),
        .load_hit     (load_hit),
        .fill_now     (fill_now),
        .store_hit    (store_hit)
    );

    assign wr_en     = fill_now || store_hit;
    assign wr_way    = fill_now ? lk_res.victim : lk_res.way;
    assign wr_data   = fill_now ? mem_rd_data : req_wdata;
    assign lru_touch = fill_now || load_hit;

    wc_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SETS   (SETS)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .lk_addr   (req_addr),
        .lk_res    (lk_res),
        .lk_data   (lk_data),
        .wr_en     (wr_en),
        .wr_fill   (fill_now),
        .wr_way    (wr_way),
        .wr_data   (wr_data),
        .lru_touch (lru_touch),
        .lru_used  (wr_way)
    );

    wc_stallcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .stall (stall),
        .count (miss_cycles)
    );

    assign rsp_rdata = fill_now ? mem_rd_data : lk_data;
    assign mem_addr  = req_addr;
    assign mem_wdata = req_wdata;
endmodule

// File: rtl/wc_chk.sv
module wc_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_write,
    input logic             stall,
    input logic             mem_rd_req,
    input logic             mem_wr_req,
    input logic             mem_rd_valid,
    input logic [CNT_W-1:0] miss_cycles
);
    // R2
    miss_stalls_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> stall);

    // R2
    single_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |=> (stall || mem_rd_valid) && !mem_rd_req);

    // R3
    fill_releases_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> !stall);

    // R5
    store_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_req |-> !stall && !mem_rd_req && req_write && req_valid);

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> miss_cycles == $past(miss_cycles) + 1'b1);

    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stall |=> $stable(miss_cycles));
endmodule

bind wordcache_2w wc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .stall        (stall),
    .mem_rd_req   (mem_rd_req),
    .mem_wr_req   (mem_wr_req),
    .mem_rd_valid (mem_rd_valid),
    .miss_cycles  (miss_cycles)
);

// File: tb/wordcache_2w_tb.sv
module wordcache_2w_tb;
    localparam int CLK_P  = 10;
    localparam int MEM_LAT = 5;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int CW = 32;
    localparam int MEM_N = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rsp_rdata;
    logic          stall, mem_rd_req, mem_wr_req, mem_rd_valid;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rd_data;
    logic [CW-1:0] miss_cycles;

    int checks = 0, errors = 0, exp_miss = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    wordcache_2w u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .stall(stall), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .miss_cycles(miss_cycles)
    );

    // fixed-latency memory model
    logic [DW-1:0] mem [MEM_N];
    logic [AW-1:0] pend_addr;
    int            pend_cnt;

    function automatic logic [DW-1:0] init_word(input int a);
        return 32'hC0DE_0000 | 32'(a);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_N; i++) mem[i] <= init_word(i);
            pend_cnt  <= 0;
            pend_addr <= '0;
        end else begin
            if (mem_wr_req) mem[mem_addr] <= mem_wdata;
            if (mem_rd_req) begin
                pend_addr <= mem_addr;
                pend_cnt  <= MEM_LAT;
            end else if (pend_cnt != 0) begin
                pend_cnt <= pend_cnt - 1;
            end
        end
    end
    assign mem_rd_valid = (pend_cnt == 1);
    assign mem_rd_data  = mem[pend_addr];

    // bench's own view of memory contents
    logic [DW-1:0] ref_mem [MEM_N];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [AW-1:0] a, input int exp_stall, input string req);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        n = 0;
        #(CLK_P/2 - 1);
        while (stall && n < 50) begin
            n++;
            @(negedge clk);
            #(CLK_P/2 - 1);
        end
        chk(rsp_rdata == ref_mem[a], {req, " data"}, rsp_rdata, ref_mem[a]);
        chk(n == exp_stall, {req, " stall"}, n, exp_stall);
        exp_miss += n;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        #(CLK_P/2 - 1);
        chk(!stall && mem_wr_req && !mem_rd_req && mem_addr == a && mem_wdata == d,
            "R5 store", {stall, mem_wr_req, mem_rd_req}, 3'b010);
        ref_mem[a] = d;
        @(posedge clk);
        #1 req_valid = 1'b0; req_write = 1'b0;
    endtask

    function automatic logic [AW-1:0] wa(input int tag, input int set);
        return AW'((tag << 2) | set);
    endfunction

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MEM_N; i++) ref_mem[i] = init_word(i);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(stall == 1'b0, "R9 stall", stall, 0);
        chk(miss_cycles == 0, "R9 count", miss_cycles, 0);

        for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] A, B, C, D;
            A = wa(1 + 8*s, s); B = wa(2 + 8*s, s);
            C = wa(3 + 8*s, s); D = wa(4 + 8*s, s);
            do_load(A, MEM_LAT, "R2 first A");        // invalid way 0 filled
            do_load(A, 0,       "R1 hit A");
            do_load(B, MEM_LAT, "R3 fill free way B");
            do_load(A, 0,       "R3 A kept");
            do_store(B, 32'h5A00_1000 | 32'(B));      // R7 store hit
            do_load(B, 0,       "R7 B new value hit"); // A now least recent
            do_store(A, 32'h5A00_2000 | 32'(A));      // R4 must not refresh A
            do_load(C, MEM_LAT, "R3 C evicts LRU");
            do_load(B, 0,       "R4 B kept over A");
            do_load(A, MEM_LAT, "R4 A was evicted"); // evicts C, data from memory
            do_load(C, MEM_LAT, "R3 C evicted");
            do_store(D, 32'h5A00_3000 | 32'(D));      // R6 store miss
            do_load(D, MEM_LAT, "R6 no allocate D");
            @(negedge clk);
            chk(miss_cycles == CW'(exp_miss), "R8 count", miss_cycles, exp_miss);
        end

        // sets kept apart: last loads of set 3 leave set 2's final pair resident
        do_load(wa(4 + 16, 2), 0, "R1 other set D hit");
        do_load(wa(3 + 16, 2), 0, "R1 other set C hit");

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule